// File: doc/BRIEF.md
# 12-bit accumulator processor core

This block is a small single-accumulator processor with a 12-bit word. It fetches one-word instructions through a synchronous, word-addressed memory port. Read data returns one clock after the address is presented. The core runs eight operations built around NOR, add, shift-right, load, store and two jumps. A single flag holds either a zero indication or a carry, depending on which operation last wrote it.

Each instruction carries a 7-bit operand and two mode bits. These bits select the current 128-word page or page zero, and direct or single-level indirect addressing. The core steps through fetch, decode, an optional indirection cycle, execute and an optional data cycle. It drives one address bus that serves both instruction and data traffic, and a one-cycle write strobe for stores. Memory and any devices behind it live outside the block.

Top module: `acc12_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_addr` is 0 and `mem_we` is 0. The accumulator and the flag start at zero, and the first instruction is fetched from address 0.
- R2: An instruction word holds the operation in bits [11:9], the indirect bit in bit 8, the page-zero bit in bit 7 and the operand in bits [6:0]. Every operation except the two jumps continues at the instruction's address plus one.
- R3: Operation 000 loads the data word into the accumulator. The flag is set when the loaded value is zero and cleared otherwise.
- R4: Operation 001 replaces the accumulator with the bitwise NOR of the accumulator and the data word. The flag is set when that result is zero.
- R5: Operation 010 adds the data word to the accumulator modulo 4096. The flag takes the carry out of bit 11.
- R6: Operation 011 loads the data word shifted right by one with a zero shifted into bit 11. The flag takes the bit shifted out of bit 0.
- R7: Operation 100 places the effective address itself in the accumulator, reads no data word and leaves the flag unchanged.
- R8: Operation 101 writes the accumulator to the effective address and leaves the accumulator and the flag unchanged.
- R9: Operation 110 continues execution at the effective address.
- R10: Operation 111 continues at the effective address when the flag is 0 and at the next address when the flag is 1. The flag is unchanged in both cases.
- R11: With bits 8:7 equal to 00, the address is the instruction address bits [11:7] followed by the operand. With 01 it is five zero bits followed by the operand. With 10 or 11 that address is read, and the word found there is the full effective address, with one level of indirection only.
- R12: The program counter wraps modulo 4096, so the instruction after one at address 0xFFF is fetched from 0x000.
- R13: An instruction takes 3 cycles, plus 1 when bit 8 is set, plus 1 for operations 000 to 011. `mem_we` is high only in the execute cycle of operation 101, which is cycle 2 counted from the fetch, or cycle 3 when the instruction is indirect. The fetch address is driven in cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address for fetch, pointer read, data read or store |
| mem_wdata | output | 12 | Store data (the accumulator) |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 12 | Read data, valid one cycle after its address |

## Verification
The only internal state visible at the ports is the sequencing. A wrong accumulator or flag stays hidden until a later store writes the accumulator or a conditional jump picks its target. The bench therefore runs a reference model next to the core and compares every store's address and data. It also compares the fetch address at the start of every instruction, at the cycle the timing rule predicts. A corrupted program counter or state register shows up within one instruction as a misplaced fetch or a stray write strobe. A corrupted accumulator or flag shows up at the next store or conditional jump that depends on it.

// File: rtl/acc12_pkg.sv
package acc12_pkg;

   localparam int unsigned OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 3'b000,
      OP_NOR   = 3'b001,
      OP_ADD   = 3'b010,
      OP_SHR   = 3'b011,
      OP_LEA   = 3'b100,
      OP_STORE = 3'b101,
      OP_JUMP  = 3'b110,
      OP_JCLR  = 3'b111
   } opcode_t;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_INDIR  = 3'd2,
      ST_EXEC   = 3'd3,
      ST_DATA   = 3'd4
   } cstate_t;

   function automatic logic op_reads_data(opcode_t op);
      return (op == OP_LOAD) || (op == OP_NOR) || (op == OP_ADD) || (op == OP_SHR);
   endfunction

endpackage

// File: rtl/acc12_ea.sv
module acc12_ea #(
   parameter int unsigned WORD_W = 12,
   parameter int unsigned OPND_W = 7
) (
   input  logic [WORD_W-OPND_W-1:0] pc_page,
   input  logic [OPND_W-1:0]        operand,
   input  logic                     zpage,
   output logic [WORD_W-1:0]        direct_addr
);
   localparam int unsigned PAGE_W = WORD_W - OPND_W;

   generate
      if (PAGE_W == 0) begin : g_bad
         $error("acc12_ea: operand must be narrower than the word");
      end
   endgenerate

   always_comb begin
      if (zpage) direct_addr = {{PAGE_W{1'b0}}, operand};
      else       direct_addr = {pc_page, operand};
   end
endmodule

// File: rtl/acc12_alu.sv
module acc12_alu
   import acc12_pkg::*;
#(
   parameter int unsigned WORD_W     = 12,
   parameter bit          RIPPLE_ADD = 1'b0
) (
   input  opcode_t           op,
   input  logic [WORD_W-1:0] acc,
   input  logic [WORD_W-1:0] mdata,
   output logic [WORD_W-1:0] result,
   output logic              flag_out
);
   logic [WORD_W-1:0] sum;
   logic              carry;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [WORD_W:0] c;
         assign c[0] = 1'b0;
         for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            assign sum[i]   = acc[i] ^ mdata[i] ^ c[i];
            assign c[i+1]   = (acc[i] & mdata[i]) | (c[i] & (acc[i] ^ mdata[i]));
         end
         assign carry = c[WORD_W];
      end else begin : g_fast
         assign {carry, sum} = {1'b0, acc} + {1'b0, mdata};
      end
   endgenerate

   always_comb begin
      result   = mdata;
      flag_out = 1'b0;
      unique case (op)
         OP_LOAD: begin
            result   = mdata;
            flag_out = (mdata == '0);
         end
         OP_NOR: begin
            result   = ~(acc | mdata);
            flag_out = ((acc | mdata) == {WORD_W{1'b1}});
         end
         OP_ADD: begin
            result   = sum;
            flag_out = carry;
         end
         OP_SHR: begin
            result   = {1'b0, mdata[WORD_W-1:1]};
            flag_out = mdata[0];
         end
         default: begin
            result   = mdata;
            flag_out = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (op == OP_NOR) assert ((result == '0) == flag_out)
         else $error("p_nor_zero_r4: zero flag disagrees with result");
   end
endmodule

// File: rtl/acc12_seq.sv
module acc12_seq
   import acc12_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  opcode_t op,
   input  logic    deref,
   output cstate_t state
);
   cstate_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: nxt = deref ? ST_INDIR : ST_EXEC;
         ST_INDIR:  nxt = ST_EXEC;
         ST_EXEC:   nxt = op_reads_data(op) ? ST_DATA : ST_FETCH;
         ST_DATA:   nxt = ST_FETCH;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_FETCH;
      else     state <= nxt;
   end

   p_fetch_then_decode_r13: assert property (@(posedge clk) disable iff (rst)
      state == ST_FETCH |=> state == ST_DECODE);
   p_indir_then_exec_r11: assert property (@(posedge clk) disable iff (rst)
      state == ST_INDIR |=> state == ST_EXEC);
endmodule

// File: rtl/acc12_core.sv
module acc12_core
   import acc12_pkg::*;
#(
   parameter int unsigned WORD_W     = 12,
   parameter int unsigned OPND_W     = 7,
   parameter bit          RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int unsigned PAGE_W  = WORD_W - OPND_W;
   localparam int unsigned DEREF_B = OPND_W + 1;
   localparam int unsigned ZPAGE_B = OPND_W;

   generate
      if (WORD_W != OPC_W + 2 + OPND_W) begin : g_bad_fields
         $error("acc12_core: word must hold opcode, two mode bits and operand");
      end
   endgenerate

   cstate_t           state;
   logic [WORD_W-1:0] pc_q, acc_q, ir_q, ea_q;
   logic              flag_q;
   logic [WORD_W-1:0] instr, direct_addr, alu_res;
   logic              alu_flag;
   opcode_t           cur_op;
   logic              cur_deref, cur_zpage;
   logic [WORD_W-1:0] pc_inc;

   // Instruction word: taken straight from memory in decode, held afterwards
   assign instr     = (state == ST_DECODE) ? mem_rdata : ir_q;
   assign cur_op    = opcode_t'(instr[WORD_W-1 -: OPC_W]);
   assign cur_deref = instr[DEREF_B];
   assign cur_zpage = instr[ZPAGE_B];
   assign pc_inc    = pc_q + 1'b1;

   acc12_seq u_seq (
      .clk   (clk),
      .rst   (rst),
      .op    (cur_op),
      .deref (cur_deref),
      .state (state)
   );

   acc12_ea #(.WORD_W(WORD_W), .OPND_W(OPND_W)) u_ea (
      .pc_page     (pc_q[WORD_W-1 -: PAGE_W]),
      .operand     (instr[OPND_W-1:0]),
      .zpage       (cur_zpage),
      .direct_addr (direct_addr)
   );

   acc12_alu #(.WORD_W(WORD_W), .RIPPLE_ADD(RIPPLE_ADD)) u_alu (
      .op       (cur_op),
      .acc      (acc_q),
      .mdata    (mem_rdata),
      .result   (alu_res),
      .flag_out (alu_flag)
   );

   // Memory port
   always_comb begin
      unique case (state)
         ST_FETCH:         mem_addr = pc_q;
         ST_DECODE:        mem_addr = direct_addr;
         ST_EXEC, ST_DATA: mem_addr = ea_q;
         default:          mem_addr = pc_q;
      endcase
   end
   assign mem_we    = (state == ST_EXEC) && (cur_op == OP_STORE);
   assign mem_wdata = acc_q;

   // Instruction and effective-address registers
   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q <= '0;
         ea_q <= '0;
      end else begin
         if (state == ST_DECODE) begin
            ir_q <= mem_rdata;
            ea_q <= direct_addr;
         end
         if (state == ST_INDIR) ea_q <= mem_rdata;
      end
   end

   // Architectural state: page of the current instruction kept until it retires
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         acc_q  <= '0;
         flag_q <= 1'b0;
      end else if (state == ST_EXEC) begin
         unique case (cur_op)
            OP_LEA: begin
               acc_q <= ea_q;
               pc_q  <= pc_inc;
            end
            OP_STORE: pc_q <= pc_inc;
            OP_JUMP:  pc_q <= ea_q;
            OP_JCLR:  pc_q <= flag_q ? pc_inc : ea_q;
            default:  ;
         endcase
      end else if (state == ST_DATA) begin
         acc_q  <= alu_res;
         flag_q <= alu_flag;
         pc_q   <= pc_inc;
      end
   end

   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pc_q == '0 && acc_q == '0 && !flag_q && state == ST_FETCH));
   p_next_addr_r2: assert property (@(posedge clk) disable iff (rst)
      state == ST_DATA |=> pc_q == $past(pc_q) + 1'b1);
   p_lea_flag_r7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && cur_op == OP_LEA) |=> $stable(flag_q));
   p_store_hold_r8: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> ($stable(acc_q) && $stable(flag_q)));
   p_jclr_skip_r10: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && cur_op == OP_JCLR && flag_q) |=> (pc_q == $past(pc_q) + 1'b1 && flag_q));
   p_strobe_single_r13: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> (!mem_we && state == ST_FETCH));
endmodule

// File: tb/sim_acc12_core.sv
`timescale 1ns/1ps
module sim_acc12_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;

   always #2.5 clk = ~clk;

   acc12_core u0 (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata)
   );

   logic [11:0] ram [4096];
   logic [11:0] mdl [4096];

   always @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
   end

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [11:0] m_pc, m_acc;
   logic        m_flag;
   string       a_tag;

   task automatic chk(bit ok, string tag, string what, logic [11:0] act, logic [11:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [11:0] enc(int op, int d, int z, int x);
      return 12'((op << 9) | (d << 8) | (z << 7) | (x & 127));
   endfunction

   task automatic put(int a, logic [11:0] w);
      ram[a] = w;
      mdl[a] = w;
   endtask

   task automatic run_prog(int n_instr);
      string prev_tag;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(mem_addr == 12'h000 && !mem_we, "R1", "bus during reset", mem_addr, 12'h000);
      m_pc = '0; m_acc = '0; m_flag = 1'b0; a_tag = "R1";
      rst = 1'b0;
      #1;
      prev_tag = "R1";
      for (int i = 0; i < n_instr; i++) begin
         logic [11:0] ir, direct, ea, dat;
         logic [12:0] s;
         int op, d, z, rd, ncyc;
         ir = mdl[m_pc];
         op = int'(ir[11:9]); d = int'(ir[8]); z = int'(ir[7]);
         direct = z ? {5'b0, ir[6:0]} : {m_pc[11:7], ir[6:0]};
         ea = d ? mdl[direct] : direct;
         rd = (op < 4) ? 1 : 0;
         ncyc = 3 + d + rd;
         chk(mem_addr == m_pc, prev_tag, "fetch address", mem_addr, m_pc);
         chk(!mem_we, "R13", "strobe in fetch", {11'b0, mem_we}, 12'h000);
         for (int c = 1; c < ncyc; c++) begin
            @(negedge clk); #1;
            if (op == 5 && c == 2 + d) begin
               chk(mem_we, "R13", "store strobe", {11'b0, mem_we}, 12'h001);
               chk(mem_addr == ea, d ? "R11" : (z ? "R11" : "R8"), "store address", mem_addr, ea);
               chk(mem_wdata == m_acc, a_tag, "store data", mem_wdata, m_acc);
            end else begin
               chk(!mem_we, "R13", "strobe outside store", {11'b0, mem_we}, 12'h000);
            end
         end
         dat = mdl[ea];
         prev_tag = (m_pc == 12'hFFF) ? "R12" : "R2";
         case (op)
            0: begin m_acc = dat; m_flag = (dat == 0); a_tag = "R3"; end
            1: begin m_acc = ~(m_acc | dat); m_flag = (m_acc == 0); a_tag = "R4"; end
            2: begin s = {1'b0, m_acc} + {1'b0, dat}; m_acc = s[11:0]; m_flag = s[12]; a_tag = "R5"; end
            3: begin m_acc = dat >> 1; m_flag = dat[0]; a_tag = "R6"; end
            4: begin m_acc = ea; a_tag = "R7"; end
            5: mdl[ea] = m_acc;
            default: ;
         endcase
         if (op == 6) begin
            m_pc = ea; prev_tag = "R9";
         end else if (op == 7) begin
            m_pc = m_flag ? m_pc + 12'd1 : ea; prev_tag = "R10";
         end else begin
            m_pc = m_pc + 12'd1;
         end
         @(negedge clk); #1;
      end
   endtask

   initial begin
      void'($urandom(32'h0005EED5));
      // Directed: carry, shift, NOR zero, LEA indirect, indirect store, page wrap
      for (int a = 0; a < 4096; a++) put(a, 12'h000);
      put(12'h000, enc(0, 0, 1, 12'h10));
      put(12'h001, enc(2, 0, 1, 12'h11));
      put(12'h002, enc(5, 0, 1, 12'h20));
      put(12'h003, enc(7, 0, 1, 12'h40));
      put(12'h004, enc(3, 0, 1, 12'h12));
      put(12'h005, enc(5, 0, 1, 12'h21));
      put(12'h006, enc(1, 0, 1, 12'h13));
      put(12'h007, enc(5, 0, 1, 12'h22));
      put(12'h008, enc(4, 1, 1, 12'h14));
      put(12'h009, enc(5, 1, 1, 12'h15));
      put(12'h00A, enc(6, 1, 1, 12'h16));
      put(12'h010, 12'hFFF);
      put(12'h011, 12'h001);
      put(12'h012, 12'h003);
      put(12'h013, 12'hFFE);
      put(12'h014, 12'hABC);
      put(12'h015, 12'h300);
      put(12'h016, 12'hFFF);
      put(12'hFFF, enc(5, 0, 0, 12'h05));
      run_prog(40);
      // Constrained random programs, biased towards all-zero and all-one words
      for (int r = 0; r < 6; r++) begin
         for (int a = 0; a < 4096; a++) begin
            int k;
            k = int'($urandom % 8);
            if (k == 0)      put(a, 12'h000);
            else if (k == 1) put(a, 12'hFFF);
            else             put(a, 12'($urandom));
         end
         run_prog(400);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule